// File: doc/BRIEF.md
# Dual-Width I/O Register Access Decoder

This block sits behind the host bus of a controller and decodes every access that falls into the controller's 32-byte I/O window. From the 5-bit byte offset, the four active-low byte enables and the read/write flag, it selects exactly one target. The targets are a 16-byte station address PROM, the register data port, the register index pointer that the two data ports share, the reset register, and the bus-configuration data port. It also drives a lane mask that tells the datapath which byte lanes carry the access, and for PROM accesses it gives the index of the 4-byte group being accessed. An access that is not legal for the current mode raises `access_err` and selects nothing, so any write it carries never reaches a register.

The window has two layouts. After a hard reset the decoder is in 16-bit word mode. A write with all four enables active at offset 10h moves it to 32-bit doubleword mode. That write still reaches the data port as a normal register write in the same cycle. From the next cycle the doubleword layout applies: the PROM is four dwords at 00h–0Ch, the data port is at 10h, the index pointer at 14h, the reset register at 18h and the bus-configuration port at 1Ch. Only full, aligned 32-bit accesses are legal there. The mode is kept in a two-state machine. It has the states `MODE_WORD` (the reset state) and `MODE_DWORD`. The transition `T_SWITCH` (word to doubleword, taken on the mode-switch write) and the self-loop `T_HOLD` are its only transitions. No path leads back to `MODE_WORD` except the hard reset `rst_n`.

Top module: `ioacc_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `dword_mode` is 0. With `acc_valid` low, all selects, `lane_mask`, `prom_grp` and `access_err` are 0 in either mode.
- R2: In word mode, a read at offset 00h–0Fh with exactly one enable active is legal when the active lane number (bit `acc_be_n[k]` low, k = 0..3) equals `acc_off[1:0]`. It asserts `sel_prom`, with `prom_grp = acc_off[3:2]`.
- R3: In word mode, a read or write at an even PROM offset is legal when `acc_be_n` is 1100 for `acc_off[1]`=0 or 0011 for `acc_off[1]`=1. It asserts `sel_prom`, with `prom_grp = acc_off[3:2]`.
- R4: In word mode, reads and writes at 10h, 12h, 14h and 16h select the data port, the index pointer, the reset register and the bus-configuration port respectively. They are legal only with `acc_be_n` = 1100 at 10h/14h and 0011 at 12h/16h.
- R5: Every other access is illegal. This includes word mode offsets 18h–1Fh, odd offsets above 0Fh, byte or dword reads of registers, no enables active, and PROM writes of a single byte. An illegal valid access asserts `access_err` and drives all selects, `lane_mask` and `prom_grp` to 0.
- R6: In word mode, a write at offset 10h with `acc_be_n` = 0000 is legal. It asserts `sel_rdp` with `lane_mask` 1111 in the same cycle, and `dword_mode` reads 1 from the next cycle. A read with the same enables and offset is illegal.
- R7: In doubleword mode, only accesses with `acc_be_n` = 0000 and `acc_off[1:0]` = 00 are legal. 00h–0Ch select the PROM, with `prom_grp = acc_off[3:2]`. 10h, 14h, 18h and 1Ch select the data port, index pointer, reset register and bus-configuration port.
- R8: Once set, `dword_mode` stays 1 whatever accesses follow, including a repeated mode-switch write, until `rst_n` is asserted.
- R9: At most one select is high in any cycle. A select is high exactly when `acc_valid` is high and `access_err` is low. For a legal access, `lane_mask` equals `~acc_be_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low; the only way back to word mode |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 5 | Byte offset within the 32-byte window |
| acc_be_n | input | 4 | Byte enables, active low, bit k = lane k |
| sel_prom | output | 1 | Address PROM selected |
| sel_rdp | output | 1 | Register data port selected |
| sel_rap | output | 1 | Register index pointer selected |
| sel_rst | output | 1 | Reset register selected |
| sel_bdp | output | 1 | Bus-configuration data port selected |
| prom_grp | output | 2 | 4-byte PROM group index for a PROM access, else 0 |
| lane_mask | output | 4 | Active-high lanes of a legal access, else 0 |
| access_err | output | 1 | Valid access outside the legal set of the current mode |
| dword_mode | output | 1 | 1 = doubleword layout active |

## Verification
Every offset is swept against every enable pattern, for both reads and writes. This runs first in word mode and then again in doubleword mode. The sweep separates lane-matched byte reads from mismatched ones, lower-half from upper-half word accesses, the reserved upper window, and the one pattern that changes the mode. The mode-switch write is placed after the word sweep and once more inside the doubleword sweep. This shows that the switch happens only once, that the switching write still lands on the data port, and that a repeated switch write changes nothing. Cycles with `acc_valid` low and a closing hard reset separate reset-only clearing from clearing by traffic.

// File: rtl/ioacc_pkg.sv
package ioacc_pkg;

    localparam int OFF_W   = 5;
    localparam int LANES   = 4;
    localparam int GRP_W   = 2;
    localparam int LANE_IW = $clog2(LANES);

    typedef enum logic {
        MODE_WORD  = 1'b0,
        MODE_DWORD = 1'b1
    } mode_t;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_PROM = 3'd1,
        TGT_RDP  = 3'd2,
        TGT_RAP  = 3'd3,
        TGT_RST  = 3'd4,
        TGT_BDP  = 3'd5
    } target_t;

    typedef struct packed {
        logic    legal;
        logic    trig;
        target_t tgt;
    } decode_t;

endpackage

// File: rtl/ioacc_word_map.sv
module ioacc_word_map
    import ioacc_pkg::*;
(
    input  logic             is_write,
    input  logic [OFF_W-1:0] off,
    input  logic [LANES-1:0] be_n,
    output decode_t          dec
);

    logic [LANES-1:0] half_pat;
    logic [LANES-1:0] byte_pat;
    logic             in_prom;
    logic             reg_even;

    always_comb begin
        half_pat = off[1] ? 4'b0011 : 4'b1100;
        byte_pat = ~(4'b0001 << off[LANE_IW-1:0]);
        in_prom  = ~off[OFF_W-1];
        reg_even = off[OFF_W-1] & ~off[3] & ~off[0];
    end

    always_comb begin
        dec       = '0;
        dec.tgt   = TGT_NONE;
        if (in_prom) begin
            if (!is_write && be_n == byte_pat) begin
                dec.legal = 1'b1;
                dec.tgt   = TGT_PROM;
            end else if (!off[0] && be_n == half_pat) begin
                dec.legal = 1'b1;
                dec.tgt   = TGT_PROM;
            end
        end else if (reg_even) begin
            if (be_n == half_pat) begin
                dec.legal = 1'b1;
                unique case (off[2:1])
                    2'd0: dec.tgt = TGT_RDP;
                    2'd1: dec.tgt = TGT_RAP;
                    2'd2: dec.tgt = TGT_RST;
                    2'd3: dec.tgt = TGT_BDP;
                endcase
            end else if (off[2:1] == 2'd0 && is_write && be_n == '0) begin
                dec.legal = 1'b1;
                dec.trig  = 1'b1;
                dec.tgt   = TGT_RDP;
            end
        end
    end

    always_comb begin
        assert (!dec.trig || (dec.legal && dec.tgt == TGT_RDP))
            else $error("p_trig_is_rdp_r6");
    end

endmodule

// File: rtl/ioacc_dword_map.sv
module ioacc_dword_map
    import ioacc_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [LANES-1:0] be_n,
    output decode_t          dec
);

    logic full_aligned;

    always_comb begin
        full_aligned = (be_n == '0) && (off[1:0] == 2'b00);
        dec          = '0;
        dec.tgt      = TGT_NONE;
        if (full_aligned) begin
            dec.legal = 1'b1;
            if (!off[OFF_W-1]) begin
                dec.tgt = TGT_PROM;
            end else begin
                unique case (off[3:2])
                    2'd0: dec.tgt = TGT_RDP;
                    2'd1: dec.tgt = TGT_RAP;
                    2'd2: dec.tgt = TGT_RST;
                    2'd3: dec.tgt = TGT_BDP;
                endcase
            end
        end
    end

endmodule

// File: rtl/ioacc_mode_fsm.sv
module ioacc_mode_fsm
    import ioacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  switch_req,
    output mode_t mode
);

    mode_t state_q;
    mode_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_WORD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WORD:  if (switch_req) state_d = MODE_DWORD;
            MODE_DWORD: state_d = MODE_DWORD;
        endcase
    end

    assign mode = state_q;

    p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_DWORD |=> state_q == MODE_DWORD);

    p_switch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_WORD && switch_req) |=> state_q == MODE_DWORD);

endmodule

// File: rtl/ioacc_decoder.sv
module ioacc_decoder
    import ioacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [LANES-1:0] acc_be_n,
    output logic             sel_prom,
    output logic             sel_rdp,
    output logic             sel_rap,
    output logic             sel_rst,
    output logic             sel_bdp,
    output logic [GRP_W-1:0] prom_grp,
    output logic [LANES-1:0] lane_mask,
    output logic             access_err,
    output logic             dword_mode
);

    decode_t dec_word;
    decode_t dec_dword;
    decode_t dec_act;
    mode_t   mode;
    logic    switch_req;

    ioacc_word_map u_word (
        .is_write (acc_write),
        .off      (acc_off),
        .be_n     (acc_be_n),
        .dec      (dec_word)
    );

    ioacc_dword_map u_dword (
        .off  (acc_off),
        .be_n (acc_be_n),
        .dec  (dec_dword)
    );

    always_comb begin
        unique case (mode)
            MODE_WORD:  dec_act = dec_word;
            MODE_DWORD: dec_act = dec_dword;
        endcase
    end

    assign switch_req = acc_valid & acc_write & dec_act.trig;

    ioacc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .switch_req (switch_req),
        .mode       (mode)
    );

    always_comb begin
        sel_prom   = 1'b0;
        sel_rdp    = 1'b0;
        sel_rap    = 1'b0;
        sel_rst    = 1'b0;
        sel_bdp    = 1'b0;
        prom_grp   = '0;
        lane_mask  = '0;
        access_err = acc_valid & ~dec_act.legal;
        if (acc_valid && dec_act.legal) begin
            lane_mask = ~acc_be_n;
            unique case (dec_act.tgt)
                TGT_PROM: begin
                    sel_prom = 1'b1;
                    prom_grp = acc_off[3:2];
                end
                TGT_RDP:  sel_rdp = 1'b1;
                TGT_RAP:  sel_rap = 1'b1;
                TGT_RST:  sel_rst = 1'b1;
                TGT_BDP:  sel_bdp = 1'b1;
                default:  ;
            endcase
        end
    end

    assign dword_mode = (mode == MODE_DWORD);

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp}));

    p_err_no_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> ({sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp} == 5'b0
                        && lane_mask == '0));

    p_dword_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dword_mode && lane_mask != '0) |-> (acc_be_n == '0 && acc_off[1:0] == 2'b00));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!access_err && lane_mask == '0 && !sel_prom && !sel_rdp));

    p_rise_by_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dword_mode) |-> $past(acc_valid && acc_write && acc_off == 5'h10
                                    && acc_be_n == 4'h0));

endmodule

// File: tb/ioacc_decoder_bench.sv
module ioacc_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [4:0] acc_off = '0;
    logic [3:0] acc_be_n = 4'hF;
    logic       sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp;
    logic [1:0] prom_grp;
    logic [3:0] lane_mask;
    logic       access_err, dword_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int ref_mode = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ioacc_decoder u_ioacc_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_off(acc_off), .acc_be_n(acc_be_n), .sel_prom(sel_prom),
        .sel_rdp(sel_rdp), .sel_rap(sel_rap), .sel_rst(sel_rst), .sel_bdp(sel_bdp),
        .prom_grp(prom_grp), .lane_mask(lane_mask), .access_err(access_err),
        .dword_mode(dword_mode)
    );

    // observed vector: {sel_prom,sel_rdp,sel_rap,sel_rst,sel_bdp, grp[1:0], lanes[3:0], err, mode}
    function automatic logic [12:0] observed();
        return {sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp, prom_grp,
                lane_mask, access_err, dword_mode};
    endfunction

    // behavioural model: target code 0 none,1 prom,2 rdp,3 rap,4 rst,5 bdp
    function automatic logic [12:0] model(input bit v, input bit w, input int off,
                                          input int be, output string tag);
        int tgt = 0;
        int lanes_on = 0;
        logic [4:0] sels;
        logic [1:0] grp;
        bit ok = 0;
        for (int k = 0; k < 4; k++) if (((be >> k) & 1) == 0) lanes_on++;
        tag = "R5";
        if (ref_mode == 0) begin
            if (off < 16) begin
                if (!w && lanes_on == 1 && ((be >> (off % 4)) & 1) == 0) begin
                    ok = 1; tag = "R2";
                end else if ((off % 4 == 0 && be == 12) || (off % 4 == 2 && be == 3)) begin
                    ok = 1; tag = "R3";
                end
                if (ok) tgt = 1;
            end else if (off == 16 && w && be == 0) begin
                ok = 1; tgt = 2; tag = "R6";
            end else if (off <= 22 && off % 2 == 0) begin
                if ((off % 4 == 0 && be == 12) || (off % 4 == 2 && be == 3)) begin
                    ok = 1; tag = "R4";
                    tgt = 2 + (off - 16) / 2;
                end
            end
        end else begin
            tag = "R7";
            if (be == 0 && off % 4 == 0) begin
                ok = 1;
                tgt = (off < 16) ? 1 : 2 + (off - 16) / 4;
            end
        end
        if (!v) begin ok = 0; tgt = 0; tag = "R1"; end
        sels = 5'b0;
        if (ok) sels[5 - tgt] = 1'b1;
        grp = (ok && tgt == 1) ? 2'((off / 4) % 4) : 2'b0;
        return {sels, grp, ok ? ~4'(be) : 4'b0, v && !ok, ref_mode != 0};
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (off=%0h be_n=%b wr=%b v=%b)",
                     tag, act, exp, acc_off, acc_be_n, acc_write, acc_valid);
        end
    endtask

    task automatic access(input bit v, input bit w, input int off, input int be);
        string tag;
        logic [12:0] exp;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_off = 5'(off); acc_be_n = 4'(be);
        #1;
        exp = model(v, w, off, be, tag);
        check(tag, observed(), exp);
        // the one-hot rule R9 on the actual outputs
        n_tests++;
        if ($countones({sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp}) > 1) begin
            n_fail++;
            $display("FAIL R9: %0d selects high, expected at most 1",
                     $countones({sel_prom, sel_rdp, sel_rap, sel_rst, sel_bdp}));
        end
        @(posedge clk);
        if (v && w && ref_mode == 0 && off == 16 && be == 0) ref_mode = 1;
    endtask

    task automatic sweep(input bit skip_switch);
        for (int w = 0; w < 2; w++)
            for (int off = 0; off < 32; off++)
                for (int be = 0; be < 16; be++)
                    if (!(skip_switch && w == 1 && off == 16 && be == 0))
                        access(1'b1, w[0], off, be);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {11'b0, access_err, dword_mode}, 13'b0);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 16, 0);          // R1: idle cycle, no switch
        sweep(1'b1);                          // word mode R2..R5, R9
        access(1'b1, 1'b1, 16, 0);          // R6: switch write
        @(negedge clk);
        check("R6", {12'b0, dword_mode}, 13'b1);
        access(1'b0, 1'b0, 0, 0);           // R1: idle in dword mode
        sweep(1'b0);                          // dword mode R7, repeated switch R8
        @(negedge clk);
        check("R8", {12'b0, dword_mode}, 13'b1);
        rst_n = 1'b0;
        #1;
        ref_mode = 0;
        check("R8", {12'b0, dword_mode}, 13'b0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 1'b0, 16, 0);          // word mode again: dword read illegal
        access(1'b1, 1'b0, 3, 7);           // R2 byte read lane 3
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule